// File: doc/BRIEF.md
# Descriptor ring queue controller

This block keeps the bookkeeping for a circular queue of job descriptors shared between software and a copy/XOR engine. Software does not move pointers itself. It writes a count of newly posted descriptors, and later a count of descriptors it has taken back. The controller keeps four pieces of state: the allocation write pointer, the engine fetch pointer, the number of completed descriptors not yet reclaimed, and the reclaim read pointer. Software reads these through a 32-bit word-indexed register port.

The engine is reduced to two signals. A fetch request/grant pair carries the slot index and its byte address in memory. A one-cycle strobe marks a completion, and completions arrive in fetch order. When the completed count rises above a programmable threshold, the block emits one interrupt message: a posted write of a programmed 32-bit data word to a programmed 48-bit address. Software masks further messages by raising the threshold to the queue size. It unmasks them by writing the threshold back to zero.

Register word indices:

| Index | Register |
|-------|----------|
| 0 | run control |
| 1 | post count |
| 2 | reclaim count |
| 3 | allocation status |
| 4 | completion status |
| 5 | size |
| 6 | threshold |
| 7 | ring base low |
| 8 | ring base high |
| 9 | message address low |
| 10 | message address high |
| 11 | message data |

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the queue is stopped, the size reads 1024, every pointer and count is zero, the threshold is zero, the error bit is clear, and neither fetch_req nor msg_valid is asserted.
- R2: Writing N to the post register (index 1) advances the allocation write pointer by N. Register index 3 returns that pointer in bits [31:16].
- R3: While running with posted descriptors outstanding, fetch_req is high. fetch_idx is the engine fetch pointer. fetch_addr equals the 48-bit ring base plus fetch_idx times 128. Each cycle with fetch_req and fetch_gnt both high advances the fetch pointer by one.
- R4: Writing 0 to the run register (index 0) starts the queue, and any nonzero value stops it. While stopped, fetch_req stays low. Run register bit 0 reads back the running state.
- R5: A done_stb pulse moves the oldest fetched descriptor into the completed state. Register index 4 reports the completed count in bits [14:0] and the oldest completed index in bits [28:16]. A strobe with nothing fetched is ignored.
- R6: Writing N to the reclaim register (index 2) lowers the completed count by N and advances the reclaim read pointer by N.
- R7: Two writes are ignored and set the sticky error bit (run register bit 1): a post that would push posted plus fetched plus completed above the size, and a reclaim larger than the completed count.
- R8: All pointers wrap modulo the programmed size.
- R9: msg_valid pulses for exactly one cycle in the first cycle the completed count exceeds the threshold. During that cycle it carries msg_addr = {message high [15:0], message low} and msg_data.
- R10: No further message is sent until the completed count has dropped to or below the threshold. Raising the threshold to the size masks messages. Dropping it to zero with a nonzero count sends a message on the next cycle.
- R11: A size write (index 5) takes effect only while the queue is stopped and empty, with a value from 1 to 4096. It clears every pointer and count. Otherwise it is ignored and sets the error bit.
- R12: The two high address registers (indices 8 and 10) keep only bits [15:0]. Their upper bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| fetch_req | output | 1 | Engine may fetch the slot at fetch_idx |
| fetch_gnt | input | 1 | Engine takes the offered slot |
| fetch_idx | output | PW | Slot index offered to the engine |
| fetch_addr | output | 48 | Byte address of the offered slot |
| done_stb | input | 1 | One-cycle completion strobe, in fetch order |
| msg_valid | output | 1 | Interrupt message write, one cycle |
| msg_addr | output | 48 | Interrupt message target address |
| msg_data | output | 32 | Interrupt message data word |

## Verification
Faults in the pointer or count registers show up at the ports within one cycle. A bad fetch pointer changes fetch_idx and fetch_addr immediately, and a bad count changes fetch_req or the status words. A missed or doubled wrap appears in the next status read after a post or reclaim crosses the end of the ring. A wrong edge-detect state shows as a missing message, or a message repeated on the cycle after the one where the count crossed the threshold. The bench compares every port against a model in every cycle, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl #(
  parameter int PW         = 12,
  parameter int DESC_LOG2  = 7,
  parameter int RESET_SIZE = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          fetch_req,
  input  logic          fetch_gnt,
  output logic [PW-1:0] fetch_idx,
  output logic [47:0]   fetch_addr,
  input  logic          done_stb,
  output logic          msg_valid,
  output logic [47:0]   msg_addr,
  output logic [31:0]   msg_data
);
  localparam int CW = PW + 1;
  localparam logic [32:0] MAX_SIZE = 33'(1) << PW;

  localparam logic [3:0] A_RUN   = 4'd0;
  localparam logic [3:0] A_POST  = 4'd1;
  localparam logic [3:0] A_RECL  = 4'd2;
  localparam logic [3:0] A_ALLOC = 4'd3;
  localparam logic [3:0] A_DONE  = 4'd4;
  localparam logic [3:0] A_SIZE  = 4'd5;
  localparam logic [3:0] A_THR   = 4'd6;
  localparam logic [3:0] A_BLO   = 4'd7;
  localparam logic [3:0] A_BHI   = 4'd8;
  localparam logic [3:0] A_MLO   = 4'd9;
  localparam logic [3:0] A_MHI   = 4'd10;
  localparam logic [3:0] A_MDAT  = 4'd11;

  logic          active, err, armed;
  logic [CW-1:0] size_q, avail, infl, done_q;
  logic [PW-1:0] wr_ptr, f_ptr, rd_ptr;
  logic [31:0]   base_lo, msg_lo, msg_dat;
  logic [15:0]   base_hi, msg_hi;
  logic [14:0]   thresh;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p,
                                             input logic [31:0]   n,
                                             input logic [CW-1:0] sz);
    logic [32:0] s;
    s = 33'(p) + 33'(n);
    if (s >= 33'(sz)) s = s - 33'(sz);
    return PW'(s);
  endfunction

  logic [32:0]   occ;
  logic          post_hit, post_ok, rec_hit, rec_ok, size_hit, size_ok;
  logic          fetch_fire, cmp_ok, above;
  logic [CW-1:0] post_n, rec_n;

  assign occ        = 33'(avail) + 33'(infl) + 33'(done_q);
  assign post_hit   = reg_we && reg_addr == A_POST;
  assign post_ok    = post_hit && (occ + 33'(reg_wdata) <= 33'(size_q));
  assign rec_hit    = reg_we && reg_addr == A_RECL;
  assign rec_ok     = rec_hit && (reg_wdata <= 32'(done_q));
  assign size_hit   = reg_we && reg_addr == A_SIZE;
  assign size_ok    = size_hit && !active && occ == 33'd0 && reg_wdata != 32'd0
                      && 33'(reg_wdata) <= MAX_SIZE;
  assign post_n     = post_ok ? CW'(reg_wdata) : '0;
  assign rec_n      = rec_ok  ? CW'(reg_wdata) : '0;

  assign fetch_req  = active && avail != '0;
  assign fetch_idx  = f_ptr;
  assign fetch_addr = {base_hi, base_lo} + (48'(f_ptr) << DESC_LOG2);
  assign fetch_fire = fetch_req && fetch_gnt;
  assign cmp_ok     = done_stb && infl != '0;

  assign above      = 15'(done_q) > thresh;
  assign msg_valid  = above && armed;
  assign msg_addr   = {msg_hi, msg_lo};
  assign msg_data   = msg_dat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      err     <= 1'b0;
      armed   <= 1'b1;
      size_q  <= CW'(RESET_SIZE);
      avail   <= '0;
      infl    <= '0;
      done_q  <= '0;
      wr_ptr  <= '0;
      f_ptr   <= '0;
      rd_ptr  <= '0;
      thresh  <= '0;
      base_lo <= '0;
      base_hi <= '0;
      msg_lo  <= '0;
      msg_hi  <= '0;
      msg_dat <= '0;
    end else begin
      armed <= !above;
      if ((post_hit && !post_ok) || (rec_hit && !rec_ok) || (size_hit && !size_ok))
        err <= 1'b1;
      if (reg_we) begin
        case (reg_addr)
          A_RUN:   active  <= reg_wdata == 32'd0;
          A_THR:   thresh  <= reg_wdata[14:0];
          A_BLO:   base_lo <= reg_wdata;
          A_BHI:   base_hi <= reg_wdata[15:0];
          A_MLO:   msg_lo  <= reg_wdata;
          A_MHI:   msg_hi  <= reg_wdata[15:0];
          A_MDAT:  msg_dat <= reg_wdata;
          default: ;
        endcase
      end
      if (size_ok) begin
        size_q <= CW'(reg_wdata);
        avail  <= '0;
        infl   <= '0;
        done_q <= '0;
        wr_ptr <= '0;
        f_ptr  <= '0;
        rd_ptr <= '0;
      end else begin
        wr_ptr <= wrap_add(wr_ptr, 32'(post_n), size_q);
        rd_ptr <= wrap_add(rd_ptr, 32'(rec_n), size_q);
        if (fetch_fire) f_ptr <= wrap_add(f_ptr, 32'd1, size_q);
        avail  <= avail + post_n - CW'(fetch_fire);
        infl   <= infl + CW'(fetch_fire) - CW'(cmp_ok);
        done_q <= done_q + CW'(cmp_ok) - rec_n;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_RUN:   reg_rdata = {30'b0, err, active};
      A_ALLOC: reg_rdata = {16'(wr_ptr), 16'b0};
      A_DONE:  reg_rdata = {3'b0, 13'(rd_ptr), 1'b0, 15'(done_q)};
      A_SIZE:  reg_rdata = 32'(size_q);
      A_THR:   reg_rdata = {17'b0, thresh};
      A_BLO:   reg_rdata = base_lo;
      A_BHI:   reg_rdata = {16'b0, base_hi};
      A_MLO:   reg_rdata = msg_lo;
      A_MHI:   reg_rdata = {16'b0, msg_hi};
      A_MDAT:  reg_rdata = msg_dat;
      default: reg_rdata = 32'b0;
    endcase
  end

  assert_occ_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= 33'(size_q));
  assert_fetch_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_add(f_ptr, 32'(avail), size_q) == wr_ptr);
  assert_reclaim_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_add(rd_ptr, 32'(infl) + 32'(done_q), size_q) == f_ptr);
  assert_msg_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !msg_valid);
  assert_bad_post_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (post_hit && !post_ok) |=> (err && $stable(wr_ptr)));
  assert_bad_reclaim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_hit && !rec_ok) |=> (err && $stable(rd_ptr)));
  assert_ptr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (33'(wr_ptr) < 33'(size_q)) && (33'(rd_ptr) < 33'(size_q)));
endmodule

// File: tb/desc_ring_ctrl_tb.sv
module desc_ring_ctrl_tb;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = 4'd0;
  logic [31:0]   reg_wdata = 32'd0;
  logic [31:0]   reg_rdata;
  logic          fetch_req, fetch_gnt = 1'b0, done_stb = 1'b0, msg_valid;
  logic [PW-1:0] fetch_idx;
  logic [47:0]   fetch_addr, msg_addr;
  logic [31:0]   msg_data;

  desc_ring_ctrl #(.PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_gnt(fetch_gnt), .fetch_idx(fetch_idx), .fetch_addr(fetch_addr),
    .done_stb(done_stb), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_active, m_err, m_armed, m_size, m_avail, m_infl, m_done;
  int m_wr, m_f, m_rd, m_thresh;
  longint m_base, m_maddr, m_mdat;

  task automatic chk(input longint got, input longint exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic int adv(input int p, input int n, input int sz);
    return (p + n) % sz;
  endfunction

  task automatic model_reset();
    m_active = 0; m_err = 0; m_armed = 1; m_size = 1024;
    m_avail = 0; m_infl = 0; m_done = 0; m_wr = 0; m_f = 0; m_rd = 0;
    m_thresh = 0; m_base = 0; m_maddr = 0; m_mdat = 0;
  endtask

  task automatic check_ports();
    bit exp_req, exp_msg;
    exp_req = (m_active != 0) && (m_avail > 0);
    exp_msg = (m_done > m_thresh) && (m_armed != 0);
    chk(longint'(fetch_req), longint'(exp_req), "R4 fetch_req");
    if (exp_req) begin
      chk(longint'(fetch_idx), longint'(m_f), "R3 fetch_idx");
      chk(longint'(fetch_addr), (m_base + longint'(m_f) * 128) & 48'hFFFF_FFFF_FFFF, "R3 fetch_addr");
    end
    chk(longint'(msg_valid), longint'(exp_msg), "R9 msg_valid");
    if (exp_msg) begin
      chk(longint'(msg_addr), m_maddr, "R9 msg_addr");
      chk(longint'(msg_data), m_mdat, "R9 msg_data");
    end
  endtask

  task automatic cyc(input bit we, input int addr, input longint wd, input bit gnt, input bit stb);
    int occ, n_av, n_in, n_dn, n_wr, n_f, n_rd;
    bit ff, cm;
    check_ports();
    reg_we = we; reg_addr = 4'(addr); reg_wdata = 32'(wd);
    fetch_gnt = gnt; done_stb = stb;
    occ = m_avail + m_infl + m_done;
    ff = gnt && m_active != 0 && m_avail > 0;
    cm = stb && m_infl > 0;
    n_av = m_avail - int'(ff); n_in = m_infl + int'(ff) - int'(cm);
    n_dn = m_done + int'(cm); n_wr = m_wr; n_rd = m_rd;
    n_f = ff ? adv(m_f, 1, m_size) : m_f;
    m_armed = (m_done > m_thresh) ? 0 : 1;
    if (we) begin
      case (addr)
        0: m_active = (wd == 0);
        1: if (occ + wd <= m_size) begin n_wr = adv(m_wr, int'(wd), m_size); n_av += int'(wd); end
           else m_err = 1;
        2: if (wd <= m_done) begin n_rd = adv(m_rd, int'(wd), m_size); n_dn -= int'(wd); end
           else m_err = 1;
        5: if (m_active == 0 && occ == 0 && wd >= 1 && wd <= 4096) begin
             m_size = int'(wd); n_av = 0; n_in = 0; n_dn = 0; n_wr = 0; n_f = 0; n_rd = 0;
           end else m_err = 1;
        6: m_thresh = int'(wd & 32'h7FFF);
        7: m_base = (m_base & 48'hFFFF_0000_0000) | (wd & 32'hFFFF_FFFF);
        8: m_base = (m_base & 32'hFFFF_FFFF) | ((wd & 16'hFFFF) << 32);
        9: m_maddr = (m_maddr & 48'hFFFF_0000_0000) | (wd & 32'hFFFF_FFFF);
        10: m_maddr = (m_maddr & 32'hFFFF_FFFF) | ((wd & 16'hFFFF) << 32);
        11: m_mdat = wd & 32'hFFFF_FFFF;
        default: ;
      endcase
    end
    m_avail = n_av; m_infl = n_in; m_done = n_dn; m_wr = n_wr; m_f = n_f; m_rd = n_rd;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; fetch_gnt = 1'b0; done_stb = 1'b0;
  endtask

  task automatic wr(input int addr, input longint wd);
    cyc(1'b1, addr, wd, 1'b0, 1'b0);
  endtask

  task automatic rd_chk(input int addr, input longint exp, input string tag);
    reg_we = 1'b0; reg_addr = 4'(addr);
    #1;
    chk(longint'(reg_rdata), exp, tag);
  endtask

  task automatic status_chk(input string tag);
    rd_chk(3, longint'(m_wr) << 16, {tag, " alloc"});
    rd_chk(4, (longint'(m_rd) << 16) | longint'(m_done), {tag, " done"});
    rd_chk(0, longint'(m_err * 2 + m_active), {tag, " run"});
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    do_reset();
    // R1 reset state
    rd_chk(0, 0, "R1 run"); rd_chk(5, 1024, "R1 size"); rd_chk(3, 0, "R1 alloc");
    rd_chk(4, 0, "R1 done"); rd_chk(6, 0, "R1 thresh");
    chk(longint'(fetch_req), 0, "R1 fetch_req"); chk(longint'(msg_valid), 0, "R1 msg");
    // R11 size write while stopped and empty
    wr(5, 8); rd_chk(5, 8, "R11 size"); rd_chk(0, 0, "R11 no err");
    // R12 high halves
    wr(7, 32'h1000_0000); wr(8, 32'hABCD_1234); rd_chk(8, 32'h1234, "R12 base hi");
    wr(9, 32'hFEE0_0040); wr(10, 32'h5555_00AA); rd_chk(10, 32'h00AA, "R12 msg hi");
    wr(11, 32'hC0DE_0001);
    // R2 post while stopped; R4 no fetch
    wr(1, 5); rd_chk(3, 5 << 16, "R2 alloc");
    chk(longint'(fetch_req), 0, "R4 stopped");
    wr(0, 0); rd_chk(0, 1, "R4 running");
    chk(longint'(fetch_req), 1, "R4 req"); chk(longint'(fetch_idx), 0, "R3 idx0");
    chk(longint'(fetch_addr), 48'h1234_1000_0000, "R3 addr0");
    for (int i = 0; i < 3; i++) cyc(1'b0, 0, 0, 1'b1, 1'b0);
    chk(longint'(fetch_idx), 3, "R3 idx3");
    chk(longint'(fetch_addr), 48'h1234_1000_0180, "R3 addr3");
    // R5 + R9: first completion fires the message
    cyc(1'b0, 0, 0, 1'b0, 1'b1);
    chk(longint'(msg_valid), 1, "R9 fire");
    chk(longint'(msg_addr), 48'h00AA_FEE0_0040, "R9 addr");
    cyc(1'b0, 0, 0, 1'b0, 1'b1);
    chk(longint'(msg_valid), 0, "R10 no repeat");
    rd_chk(4, 2, "R5 done");
    // R10 mask, reclaim, unmask
    wr(6, 8); wr(2, 2); rd_chk(4, (2 << 16) | 0, "R6 reclaim");
    cyc(1'b0, 0, 0, 1'b0, 1'b1);
    chk(longint'(msg_valid), 0, "R10 masked");
    wr(6, 0);
    chk(longint'(msg_valid), 1, "R10 unmask fires");
    // R5 stray strobe with nothing fetched
    cyc(1'b0, 0, 0, 1'b0, 1'b1);
    rd_chk(4, (2 << 16) | 1, "R5 stray strobe");
    // R8 wrap
    wr(1, 3); rd_chk(3, 0, "R8 wrap");
    // R7 oversized post and reclaim
    wr(1, 3); rd_chk(3, 0, "R7 post ignored"); rd_chk(0, 3, "R7 err");
    wr(2, 5); rd_chk(4, (2 << 16) | 1, "R7 reclaim ignored");
    // R4 stop, R11 size ignored when active or nonempty
    wr(5, 16); rd_chk(5, 8, "R11 active ignore");
    wr(0, 1); chk(longint'(fetch_req), 0, "R4 stop");
    wr(5, 16); rd_chk(5, 8, "R11 nonempty ignore");

    // random phase
    do_reset();
    wr(5, 8 + 8 * ($urandom % 2));
    wr(7, 32'h0002_0000); wr(9, 32'h0000_1000); wr(11, 32'h0BAD_F00D);
    wr(0, 0);
    for (int i = 0; i < 3000; i++) begin
      int op;
      longint wd;
      bit w;
      int a;
      op = $urandom % 8; w = 1'b1; a = 0; wd = 0;
      case (op)
        0: begin a = 1; wd = $urandom % (m_size + 2); end
        1: begin a = 2; wd = $urandom % (m_done + 2); end
        2: begin a = 6; wd = $urandom % 4; end
        3: begin a = 0; wd = ($urandom % 6 == 0) ? 1 : 0; end
        default: w = 1'b0;
      endcase
      cyc(w, a, wd, 1'($urandom % 2), 1'($urandom % 2));
      status_chk("R8 random");
    end
    cyc(1'b0, 0, 0, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule